// File: doc/BRIEF.md
# Adaptive Home-Node Lock Arbiter

This block is the home arbiter for a share of the system's locks. Nodes send it acquire and release messages, and it replies with one of four message kinds: an uncachable grant, a cachable grant, a forward request addressed to the node at the end of the ownership chain, or a recall sent to a node that holds a cached lock. Each lock has exactly one home arbiter, chosen by its lock number. This instance takes part only in traffic for the locks homed at `HOME_NODE`.

For each of its locks the arbiter tracks the access pattern and picks one of three behaviours. By default ownership returns to the arbiter on every release. A node that acquires the same lock several times in a row, with no other node asking in between, gets a cachable grant and can reuse the lock without sending any message. When requests pile up, each new requester is chained behind the last one, so that ownership moves from node to node in a single hop.

Every accepted message produces at most one outgoing message, and that message is registered one cycle after the input.

Top module: `lockmgr_top`

## Requirements
- R1: After reset the output is idle and every homed lock is free, not cached, and in centralized mode.
- R2: A message is acted on only when `inLock mod NUM_NODES == HOME_NODE`. Any other lock id produces no output and no state change.
- R3: An acquire of a free lock produces a grant to the requester in the next cycle. The grant is uncachable (kind 0) unless R6 applies, so an idle acquire costs exactly one request and one grant.
- R4: In centralized mode, an acquire of a busy lock from a new node is queued silently. Each valid release while the queue is non-empty sends an uncachable grant to the oldest queued node (FIFO).
- R5: A release is valid only from the current owner, or from the chain tail when in forwarding mode with an empty queue. Any other release is ignored.
- R6: When a free lock is acquired by the same node for the `CACHE_THRESH`-th time in a row (default 3), the grant is cachable (kind 1). An acquire from any other node restarts the count at one.
- R7: An acquire of a cached lock from another node sends a recall (kind 3) to the caching node, with `outReq` set to the requester, and queues the requester. The cacher's later release grants the lock to that requester.
- R8: When queuing a request makes the queue depth 2, the lock enters forwarding mode. Each later acquire from a new node sends a forward (kind 2) to the current chain tail, with `outReq` set to the requester, and that requester becomes the new tail.
- R9: A valid release that finds the queue empty frees the lock and returns it to centralized mode. The next acquire is then granted at once.
- R10: An acquire from the current owner or the chain tail of a busy lock produces no message.
- R11: Output appears only in the cycle after an accepted input, and there is at most one output message per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Incoming message present |
| inIsRel | input | 1 | 1 = release, 0 = acquire |
| inNode | input | $clog2(NUM_NODES) | Sending node |
| inLock | input | $clog2(NUM_LOCKS) | Lock id |
| outValid | output | 1 | Outgoing message present |
| outKind | output | 2 | 0 uncachable grant, 1 cachable grant, 2 forward, 3 recall |
| outDst | output | $clog2(NUM_NODES) | Destination node |
| outReq | output | $clog2(NUM_NODES) | Node on whose behalf the message is sent |
| outLock | output | $clog2(NUM_LOCKS) | Lock id |

## Verification
The hardest state to reach is forwarding mode while older requests are still in the queue. In that state the manager must keep granting queued nodes in FIFO order, ignore the release of a node that handed off directly, and free the lock only when the chain tail releases. The stimulus builds this state on purpose: one holder, then two waiters so that the queue depth reaches 2, then a third requester that must be forwarded. The bench then replays the releases in chain order and checks that a fresh acquire afterwards is granted at once. A separate sequence counts same-node acquires across an interruption by another node before it reaches the cachable grant and the recall.

// File: rtl/lockmgr_pkg.sv
package lockmgr_pkg;

  typedef enum logic [1:0] {
    MSG_GRANT_U = 2'd0,
    MSG_GRANT_C = 2'd1,
    MSG_FWD     = 2'd2,
    MSG_RECALL  = 2'd3
  } outKind_e;

  // strobes from control to datapath, already gated by an accepted message
  typedef struct packed {
    logic grantU;
    logic grantC;
    logic track;
    logic enqueue;
    logic setFwd;
    logic recall;
    logic forward;
    logic popGrant;
    logic freeLock;
  } mgrCtl_t;

endpackage

// File: rtl/lockmgr_ctrl.sv
module lockmgr_ctrl
  import lockmgr_pkg::*;
#(
  parameter int NW           = 3,
  parameter int CW           = 2,
  parameter int QCW          = 4,
  parameter int CACHE_THRESH = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic           inIsRel,
  input  logic [NW-1:0]  inNode,
  input  logic           homed,
  input  logic           selBusy,
  input  logic           selCached,
  input  logic           selFwd,
  input  logic [NW-1:0]  selOwner,
  input  logic [NW-1:0]  selTail,
  input  logic [NW-1:0]  selLast,
  input  logic [CW-1:0]  selCnt,
  input  logic [QCW-1:0] selCount,
  output logic [CW-1:0]  cntNext,
  output mgrCtl_t        ctl
);

  logic act, qEmpty, relOk, selfChain;

  assign act       = inValid && homed;
  assign qEmpty    = (selCount == '0);
  assign selfChain = (inNode == selOwner) || (inNode == selTail);
  assign relOk     = selBusy && ((selFwd && qEmpty) ? (inNode == selTail) : (inNode == selOwner));

  always_comb begin
    if (selCnt != '0 && inNode == selLast)
      cntNext = (selCnt >= CW'(CACHE_THRESH)) ? selCnt : selCnt + 1'b1;
    else
      cntNext = CW'(1);
  end

  always_comb begin
    ctl = '0;
    if (act && !inIsRel) begin
      if (!selBusy) begin
        ctl.track = 1'b1;
        if (cntNext >= CW'(CACHE_THRESH)) ctl.grantC = 1'b1;
        else                              ctl.grantU = 1'b1;
      end else if (!selfChain) begin
        ctl.track = 1'b1;
        if (selFwd) begin
          ctl.forward = 1'b1;
        end else begin
          ctl.enqueue = 1'b1;
          ctl.recall  = selCached;
          ctl.setFwd  = (selCount == QCW'(1));
        end
      end
    end else if (act && inIsRel && relOk) begin
      if (!qEmpty) ctl.popGrant = 1'b1;
      else         ctl.freeLock = 1'b1;
    end
  end

  // R7: a recall only goes out for a lock that is busy and cached
  a_r7_recall_cached: assert property (@(posedge clk) disable iff (!rstN)
    ctl.recall |-> (selBusy && selCached && !inIsRel));

  // R5: a release from a node that is neither owner nor tail never takes effect
  a_r5_foreign_release: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inIsRel && inNode != selOwner && inNode != selTail)
      |-> !(ctl.popGrant || ctl.freeLock));

endmodule

// File: rtl/lockmgr_dp.sv
module lockmgr_dp
  import lockmgr_pkg::*;
#(
  parameter int NW    = 3,
  parameter int LW    = 4,
  parameter int CW    = 2,
  parameter int PW    = 3,
  parameter int QCW   = 4,
  parameter int SW    = 1,
  parameter int LOCAL = 2,
  parameter int DEPTH = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic           inIsRel,
  input  logic [NW-1:0]  inNode,
  input  logic [LW-1:0]  inLock,
  input  logic           homed,
  input  logic [SW-1:0]  slot,
  input  mgrCtl_t        ctl,
  input  logic [CW-1:0]  cntNext,
  output logic           selBusy,
  output logic           selCached,
  output logic           selFwd,
  output logic [NW-1:0]  selOwner,
  output logic [NW-1:0]  selTail,
  output logic [NW-1:0]  selLast,
  output logic [CW-1:0]  selCnt,
  output logic [QCW-1:0] selCount,
  output logic           outValid,
  output logic [1:0]     outKind,
  output logic [NW-1:0]  outDst,
  output logic [NW-1:0]  outReq,
  output logic [LW-1:0]  outLock
);

  logic           busyV   [LOCAL];
  logic           cachedV [LOCAL];
  logic           fwdV    [LOCAL];
  logic [NW-1:0]  ownerV  [LOCAL];
  logic [NW-1:0]  tailV   [LOCAL];
  logic [NW-1:0]  lastV   [LOCAL];
  logic [CW-1:0]  cntV    [LOCAL];
  logic [QCW-1:0] countV  [LOCAL];
  logic [NW-1:0]  headV   [LOCAL];

  for (genvar i = 0; i < LOCAL; i++) begin : g_slot
    logic           busyQ, cachedQ, fwdQ, hit;
    logic [NW-1:0]  ownerQ, tailQ, lastQ;
    logic [CW-1:0]  cntQ;
    logic [PW-1:0]  headQ, wrIdx, headInc;
    logic [QCW-1:0] countQ, wrSum;
    logic [NW-1:0]  qMem [DEPTH];

    assign hit     = homed && (slot == SW'(i));
    assign headInc = (headQ == PW'(DEPTH - 1)) ? '0 : headQ + 1'b1;

    always_comb begin
      wrSum = {1'b0, headQ} + countQ;
      if (wrSum >= QCW'(DEPTH)) wrSum = wrSum - QCW'(DEPTH);
      wrIdx = wrSum[PW-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        busyQ <= 1'b0; cachedQ <= 1'b0; fwdQ <= 1'b0;
        ownerQ <= '0; tailQ <= '0; lastQ <= '0;
        cntQ <= '0; headQ <= '0; countQ <= '0;
      end else if (hit) begin
        if (ctl.grantU || ctl.grantC) begin
          busyQ <= 1'b1; cachedQ <= ctl.grantC; ownerQ <= inNode; tailQ <= inNode;
        end
        if (ctl.track)   begin lastQ <= inNode; cntQ <= cntNext; end
        if (ctl.enqueue) begin countQ <= countQ + 1'b1; tailQ <= inNode; end
        if (ctl.setFwd)  fwdQ <= 1'b1;
        if (ctl.recall)  cachedQ <= 1'b0;
        if (ctl.forward) tailQ <= inNode;
        if (ctl.popGrant) begin
          ownerQ <= qMem[headQ]; headQ <= headInc; countQ <= countQ - 1'b1;
        end
        if (ctl.freeLock) begin busyQ <= 1'b0; fwdQ <= 1'b0; cachedQ <= 1'b0; end
      end
    end

    always_ff @(posedge clk) begin
      if (hit && ctl.enqueue) qMem[wrIdx] <= inNode;
    end

    assign busyV[i]   = busyQ;
    assign cachedV[i] = cachedQ;
    assign fwdV[i]    = fwdQ;
    assign ownerV[i]  = ownerQ;
    assign tailV[i]   = tailQ;
    assign lastV[i]   = lastQ;
    assign cntV[i]    = cntQ;
    assign countV[i]  = countQ;
    assign headV[i]   = qMem[headQ];

    // R4: the per-lock FIFO never holds more entries than there are nodes
    a_r4_queue_bound: assert property (@(posedge clk) disable iff (!rstN)
      countQ <= QCW'(DEPTH));

    // R9: forwarding mode only exists while the lock is owned
    a_r9_fwd_busy: assert property (@(posedge clk) disable iff (!rstN)
      fwdQ |-> busyQ);
  end

  assign selBusy   = busyV[slot];
  assign selCached = cachedV[slot];
  assign selFwd    = fwdV[slot];
  assign selOwner  = ownerV[slot];
  assign selTail   = tailV[slot];
  assign selLast   = lastV[slot];
  assign selCnt    = cntV[slot];
  assign selCount  = countV[slot];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0; outKind <= '0; outDst <= '0; outReq <= '0; outLock <= '0;
    end else begin
      outValid <= ctl.grantU || ctl.grantC || ctl.popGrant || ctl.forward || ctl.recall;
      outLock  <= inLock;
      outReq   <= ctl.popGrant ? headV[slot] : inNode;
      if (ctl.grantC) begin
        outKind <= MSG_GRANT_C; outDst <= inNode;
      end else if (ctl.forward) begin
        outKind <= MSG_FWD; outDst <= selTail;
      end else if (ctl.recall) begin
        outKind <= MSG_RECALL; outDst <= selOwner;
      end else if (ctl.popGrant) begin
        outKind <= MSG_GRANT_U; outDst <= headV[slot];
      end else begin
        outKind <= MSG_GRANT_U; outDst <= inNode;
      end
    end
  end

  // R11: no outgoing message without an input one cycle earlier
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));

  // R3: an acquire of a free homed lock is granted to the requester next cycle
  a_r3_free_grant: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inIsRel && homed && !selBusy) |=>
      (outValid && (outKind == MSG_GRANT_U || outKind == MSG_GRANT_C) && outDst == $past(inNode)));

  // R10: a forward is never addressed to the node it serves
  a_r10_fwd_not_self: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == MSG_FWD) |-> (outDst != outReq));

endmodule

// File: rtl/lockmgr_top.sv
module lockmgr_top
  import lockmgr_pkg::*;
#(
  parameter int NUM_LOCKS    = 16,
  parameter int NUM_NODES    = 8,
  parameter int HOME_NODE    = 0,
  parameter int CACHE_THRESH = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  input  logic                         inIsRel,
  input  logic [$clog2(NUM_NODES)-1:0] inNode,
  input  logic [$clog2(NUM_LOCKS)-1:0] inLock,
  output logic                         outValid,
  output logic [1:0]                   outKind,
  output logic [$clog2(NUM_NODES)-1:0] outDst,
  output logic [$clog2(NUM_NODES)-1:0] outReq,
  output logic [$clog2(NUM_LOCKS)-1:0] outLock
);

  localparam int NW    = $clog2(NUM_NODES);
  localparam int LW    = $clog2(NUM_LOCKS);
  localparam int DEPTH = NUM_NODES;
  localparam int PW    = $clog2(DEPTH);
  localparam int QCW   = PW + 1;
  localparam int CW    = $clog2(CACHE_THRESH + 1);
  localparam int LOCAL = (NUM_LOCKS - HOME_NODE + NUM_NODES - 1) / NUM_NODES;
  localparam int SW    = (LOCAL > 1) ? $clog2(LOCAL) : 1;

  logic           homed;
  logic [SW-1:0]  slot;
  int unsigned    slotFull;
  logic           selBusy, selCached, selFwd;
  logic [NW-1:0]  selOwner, selTail, selLast;
  logic [CW-1:0]  selCnt, cntNext;
  logic [QCW-1:0] selCount;
  mgrCtl_t        ctl;

  always_comb begin
    slotFull = 32'(inLock) / NUM_NODES;
    homed    = ((32'(inLock) % NUM_NODES) == HOME_NODE) && (slotFull < LOCAL);
    slot     = slotFull[SW-1:0];
  end

  lockmgr_ctrl #(.NW(NW), .CW(CW), .QCW(QCW), .CACHE_THRESH(CACHE_THRESH)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inIsRel(inIsRel), .inNode(inNode),
    .homed(homed), .selBusy(selBusy), .selCached(selCached), .selFwd(selFwd),
    .selOwner(selOwner), .selTail(selTail), .selLast(selLast), .selCnt(selCnt),
    .selCount(selCount), .cntNext(cntNext), .ctl(ctl)
  );

  lockmgr_dp #(.NW(NW), .LW(LW), .CW(CW), .PW(PW), .QCW(QCW), .SW(SW),
               .LOCAL(LOCAL), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inIsRel(inIsRel), .inNode(inNode),
    .inLock(inLock), .homed(homed), .slot(slot), .ctl(ctl), .cntNext(cntNext),
    .selBusy(selBusy), .selCached(selCached), .selFwd(selFwd), .selOwner(selOwner),
    .selTail(selTail), .selLast(selLast), .selCnt(selCnt), .selCount(selCount),
    .outValid(outValid), .outKind(outKind), .outDst(outDst), .outReq(outReq),
    .outLock(outLock)
  );

endmodule

// File: tb/sim_lockmgr_top.sv
`timescale 1ns/1ps
module sim_lockmgr_top;

  localparam int NODES = 8;
  localparam int LOCKS = 16;
  localparam int NW = $clog2(NODES);
  localparam int LW = $clog2(LOCKS);
  localparam int GU = 0, GC = 1, FW = 2, RC = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inIsRel = 1'b0;
  logic [NW-1:0] inNode = '0;
  logic [LW-1:0] inLock = '0;
  logic outValid;
  logic [1:0] outKind;
  logic [NW-1:0] outDst, outReq;
  logic [LW-1:0] outLock;

  int checks = 0, fails = 0;
  logic gV; logic [1:0] gK; logic [NW-1:0] gD, gR; logic [LW-1:0] gL;

  always #10 clk = ~clk;

  lockmgr_top #(.NUM_LOCKS(LOCKS), .NUM_NODES(NODES), .HOME_NODE(0), .CACHE_THRESH(3)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inIsRel(inIsRel), .inNode(inNode),
    .inLock(inLock), .outValid(outValid), .outKind(outKind), .outDst(outDst),
    .outReq(outReq), .outLock(outLock)
  );

  task automatic send(input bit rel, input int node, input int lock);
    @(negedge clk);
    inValid = 1'b1; inIsRel = rel; inNode = NW'(node); inLock = LW'(lock);
    @(negedge clk);
    inValid = 1'b0;
    gV = outValid; gK = outKind; gD = outDst; gR = outReq; gL = outLock;
  endtask

  task automatic expectMsg(input bit v, input int kind, input int dst, input int req,
                           input int lock, input string tag);
    bit bad;
    checks++;
    bad = (gV != v);
    if (v && !bad) bad = (gK != 2'(kind)) || (gD != NW'(dst)) || (gR != NW'(req)) || (gL != LW'(lock));
    if (bad) begin
      fails++;
      $display("FAIL %s: got v=%0d k=%0d d=%0d r=%0d l=%0d exp v=%0d k=%0d d=%0d r=%0d l=%0d",
               tag, gV, gK, gD, gR, gL, v, kind, dst, req, lock);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      fails++; $display("FAIL R1: outValid=%0d exp 0", outValid);
    end
    send(0, 1, 0); expectMsg(1, GU, 1, 1, 0, "R1 free after reset / R3 idle grant");
    send(1, 1, 0); expectMsg(0, 0, 0, 0, 0, "R9 release to manager silent");
  endtask

  task automatic t_home;
    send(0, 2, 3); expectMsg(0, 0, 0, 0, 0, "R2 foreign lock acquire ignored");
    send(0, 2, 8); expectMsg(1, GU, 2, 2, 8, "R2 homed lock 8 granted");
    send(0, 4, 3); expectMsg(0, 0, 0, 0, 0, "R2 foreign lock still ignored");
    send(1, 2, 8); expectMsg(0, 0, 0, 0, 0, "R9 lock 8 released");
  endtask

  task automatic t_fifo;
    send(0, 1, 0); expectMsg(1, GU, 1, 1, 0, "R3 grant node1");
    send(1, 5, 0); expectMsg(0, 0, 0, 0, 0, "R5 release from non-owner");
    send(0, 2, 0); expectMsg(0, 0, 0, 0, 0, "R5 lock still busy, R4 queued");
    send(1, 1, 0); expectMsg(1, GU, 2, 2, 0, "R4 queued node granted on release");
    send(1, 2, 0); expectMsg(0, 0, 0, 0, 0, "R9 release with empty queue");
    send(0, 3, 0); expectMsg(1, GU, 3, 3, 0, "R9 free again");
    send(1, 3, 0); expectMsg(0, 0, 0, 0, 0, "R9 release");
  endtask

  task automatic t_cache;
    send(0, 4, 0); expectMsg(1, GU, 4, 4, 0, "R6 first acquire uncachable");
    send(1, 4, 0);
    send(0, 4, 0); expectMsg(1, GU, 4, 4, 0, "R6 second acquire uncachable");
    send(1, 4, 0);
    send(0, 6, 0); expectMsg(1, GU, 6, 6, 0, "R6 other node interrupts run");
    send(1, 6, 0);
    send(0, 4, 0); expectMsg(1, GU, 4, 4, 0, "R6 count restarted");
    send(1, 4, 0);
    send(0, 4, 0); expectMsg(1, GU, 4, 4, 0, "R6 second of new run");
    send(1, 4, 0);
    send(0, 4, 0); expectMsg(1, GC, 4, 4, 0, "R6 third consecutive is cachable");
    send(0, 4, 0); expectMsg(0, 0, 0, 0, 0, "R10 owner reacquire silent");
    send(0, 5, 0); expectMsg(1, RC, 4, 5, 0, "R7 recall to cacher");
    send(1, 4, 0); expectMsg(1, GU, 5, 5, 0, "R7 cacher release grants requester");
    send(1, 5, 0); expectMsg(0, 0, 0, 0, 0, "R9 release");
  endtask

  task automatic t_forward;
    send(0, 1, 0); expectMsg(1, GU, 1, 1, 0, "R3 holder");
    send(0, 2, 0); expectMsg(0, 0, 0, 0, 0, "R4 first waiter queued");
    send(0, 3, 0); expectMsg(0, 0, 0, 0, 0, "R8 second waiter queued, depth 2");
    send(0, 7, 0); expectMsg(1, FW, 3, 7, 0, "R8 forward to tail");
    send(0, 7, 0); expectMsg(0, 0, 0, 0, 0, "R10 tail reacquire silent");
    send(1, 1, 0); expectMsg(1, GU, 2, 2, 0, "R4 FIFO first");
    send(1, 2, 0); expectMsg(1, GU, 3, 3, 0, "R4 FIFO second");
    send(1, 3, 0); expectMsg(0, 0, 0, 0, 0, "R5 handoff node release ignored");
    send(0, 6, 0); expectMsg(1, FW, 7, 6, 0, "R9 still forwarding before tail release");
    send(1, 7, 0); expectMsg(0, 0, 0, 0, 0, "R5 old tail release ignored");
    send(1, 6, 0); expectMsg(0, 0, 0, 0, 0, "R9 tail release frees");
    send(0, 5, 0); expectMsg(1, GU, 5, 5, 0, "R9 centralized grant");
    send(0, 0, 0); expectMsg(0, 0, 0, 0, 0, "R9 central mode queues");
    send(1, 5, 0); expectMsg(1, GU, 0, 0, 0, "R4 central pop");
    send(1, 0, 0); expectMsg(0, 0, 0, 0, 0, "R9 release");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_home();
    t_fifo();
    t_cache();
    t_forward();
    repeat (2) @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      fails++; $display("FAIL R11: outValid=%0d exp 0 with no input", outValid);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule